// File: doc/BRIEF.md
# Module Clock Stop Controller

This block holds one stop bit per peripheral module in a control register and turns each bit into a clock-enable output. A set bit stops the clock and a clear bit lets it run. A second, read-only register reports whether each module's clock is actually stopped. A status bit reads 1 while the module is stopped or has not yet confirmed that it is running. When a module is started, its status bit clears only after a per-module acknowledge delay. Software must therefore poll the status bit after an enable. It gives up after 1000 polls and reports a timeout. A stop takes effect in status at once, so a disable needs no wait.

Software reaches both registers through a single-request register port with byte, halfword or word access. Reads are returned one cycle after the request. An enable is normally a read-modify-write that clears one bit and keeps the others. Narrow writes allow the same thing without a read, because they only touch the lanes they address. Each module's acknowledge delay comes from a base plus a per-index step. A module can be built with its acknowledge tied off, and its status then never clears.

Top module: `modstop_clk_ctrl`

## Requirements
- R1: After reset every implemented stop bit is 1, every status bit reads 1 and every clock-enable output is 0.
- R2: A stop bit of 1 drives the module's clock-enable output low, and 0 drives it high, from the edge that writes the bit.
- R3: A write touches only the byte lanes it addresses. Size code 0 is a byte at lane addr[1:0], code 1 is a halfword at lanes {addr[1],0} and {addr[1],1}, and code 2 or 3 is the whole word. Write data sits in the low bits of wdata. Address bit 2 selects the register: 0 is control, 1 is status.
- R4: A read returns the addressed lanes of the selected register, shifted down to bit 0 and zero-extended.
- R5: After module i's stop bit is cleared at edge E0, its status bit reads 1 for a read issued at edge E0+D_i and reads 0 for a read issued at edge E0+D_i+1. Here D_i = DLY_BASE + DLY_STEP*i.
- R6: A read issued on the edge after a stop write already returns status 1 for that module.
- R7: Setting the stop bit again before the acknowledge completes cancels it. A later clear waits the full D_i again.
- R8: A module whose acknowledge is tied off keeps status 1 while its stop bit is 0. Software polling it gives up after 1000 reads.
- R9: Writes to the status register change neither register.
- R10: Bits at positions NUM_MOD and above read 0, and writes to them are dropped.
- R11: rvalid is high exactly one cycle after each read request and low after a write, with rdata valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Bit 2 register select, bits 1:0 byte offset |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Write data, low aligned |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data, low aligned |
| clk_en_o | output | NUM_MOD | Per-module clock enable |

## Verification
The hardest condition to reach from the ports is a stop arriving in the middle of a running acknowledge countdown, followed by a fresh enable. Without restart logic, that sequence would let status clear early. The stimulus writes the enable, waits part of the module's delay, then writes stop and enable on two consecutive edges. It then reads status on the exact edge where a restarted count must still show 1, and on the next edge, where it must show 0. The never-acknowledging module is driven through the full 1000-read poll to reach the timeout path.

// File: rtl/modstop_pkg.sv
package modstop_pkg;

  localparam int REG_W  = 32;
  localparam int LANES  = REG_W / 8;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORD2 = 2'd3
  } acc_size_e;

endpackage

// File: rtl/modstop_lane.sv
module modstop_lane
  import modstop_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [1:0]       off_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] wr_img_i,
  input  logic [REG_W-1:0] rd_img_i,
  output logic [REG_W-1:0] merged_o,
  output logic [REG_W-1:0] rd_val_o
);

  logic [LANES-1:0] lane_en;
  logic [REG_W-1:0] wshift;
  logic [REG_W-1:0] bit_en;

  always_comb begin
    unique case (acc_size_e'(size_i))
      ACC_BYTE: begin
        lane_en  = LANES'(1) << off_i;
        wshift   = REG_W'(wdata_i[7:0]) << (8 * off_i);
        rd_val_o = REG_W'((rd_img_i >> (8 * off_i)) & REG_W'(8'hFF));
      end
      ACC_HALF: begin
        lane_en  = off_i[1] ? 4'b1100 : 4'b0011;
        wshift   = REG_W'(wdata_i[15:0]) << (16 * off_i[1]);
        rd_val_o = REG_W'((rd_img_i >> (16 * off_i[1])) & REG_W'(16'hFFFF));
      end
      default: begin
        lane_en  = '1;
        wshift   = wdata_i;
        rd_val_o = rd_img_i;
      end
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bit_en[8*l +: 8] = {8{lane_en[l]}};
  end

  assign merged_o = (wr_img_i & ~bit_en) | (wshift & bit_en);

endmodule

// File: rtl/modstop_ack_track.sv
module modstop_ack_track #(
  parameter int   CNT_W     = 8,
  parameter int   DELAY     = 2,
  parameter logic ACK_WIRED = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic status_o
);

  if (ACK_WIRED) begin : g_ack
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             run_q, run_d;
    logic             cnt_en;

    always_comb begin
      cnt_d  = cnt_q;
      run_d  = run_q;
      cnt_en = 1'b0;
      if (stop_i) begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        run_d  = 1'b0;
      end else if (!run_q) begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          cnt_d = '0;
          run_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
        run_q <= run_d;
      end
    end

    assign status_o = stop_i | ~run_q;

    // R6: a stop withdraws the run acknowledge on the next edge
    a_r6_stop_drops_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> !run_q);
    // R5: the acknowledge can only rise after a cycle with the clock running
    a_r5_ack_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_q) |-> $past(!stop_i));
    // R5: the countdown never passes its terminal value
    a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);
    // R7: a stop during the countdown restarts it from zero
    a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> cnt_q == '0);
  end else begin : g_tied
    assign status_o = 1'b1;
  end

endmodule

// File: rtl/modstop_clk_ctrl.sv
module modstop_clk_ctrl
  import modstop_pkg::*;
#(
  parameter int                 NUM_MOD     = 12,
  parameter int                 DLY_BASE    = 2,
  parameter int                 DLY_STEP    = 3,
  parameter int                 CNT_W       = 8,
  parameter logic [NUM_MOD-1:0] ACK_PRESENT = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [1:0]         size_i,
  input  logic [31:0]        wdata_i,
  output logic               rvalid_o,
  output logic [31:0]        rdata_o,
  output logic [NUM_MOD-1:0] clk_en_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [NUM_MOD-1:0] stop_q, stop_d;
  logic [NUM_MOD-1:0] status;
  logic [REG_W-1:0]   ctrl_img, stat_img, rd_img, merged, rd_val;
  logic               wr_ctrl, rd_req;
  logic               rvalid_d;
  logic [REG_W-1:0]   rdata_q, rdata_d;

  assign ctrl_img = REG_W'(stop_q);
  assign stat_img = REG_W'(status);
  assign rd_img   = addr_i[2] ? stat_img : ctrl_img;
  assign wr_ctrl  = req_i & we_i & ~addr_i[2];
  assign rd_req   = req_i & ~we_i;

  modstop_lane i_lane (
    .size_i   (size_i),
    .off_i    (addr_i[1:0]),
    .wdata_i  (wdata_i),
    .wr_img_i (ctrl_img),
    .rd_img_i (rd_img),
    .merged_o (merged),
    .rd_val_o (rd_val)
  );

  always_comb begin
    stop_d   = stop_q;
    rdata_d  = rdata_q;
    rvalid_d = rd_req;
    if (wr_ctrl) stop_d  = merged[NUM_MOD-1:0];
    if (rd_req)  rdata_d = rd_val;
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      stop_q   <= '1;
      rvalid_o <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_o <= rvalid_d;
      if (wr_ctrl) stop_q  <= stop_d;
      if (rd_req)  rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign clk_en_o = ~stop_q;

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
    modstop_ack_track #(
      .CNT_W     (CNT_W),
      .DELAY     (DLY_BASE + DLY_STEP * i),
      .ACK_WIRED (ACK_PRESENT[i])
    ) i_track (
      .clk_i    (clk_i),
      .rst_ni   (rst_q),
      .stop_i   (stop_q[i]),
      .status_o (status[i])
    );
  end

  // R11: read data is valid one cycle after each read request
  a_r11_rvalid_rise: assert property (@(posedge clk_i) disable iff (!rst_q)
    rd_req |=> rvalid_o);
  a_r11_rvalid_quiet: assert property (@(posedge clk_i) disable iff (!rst_q)
    !rd_req |=> !rvalid_o);
  // R9: writes aimed at the status register leave control untouched
  a_r9_status_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_q)
    (req_i && we_i && addr_i[2]) |=> $stable(stop_q));
  // R2: without a control write the enables hold
  a_r2_enable_hold: assert property (@(posedge clk_i) disable iff (!rst_q)
    !wr_ctrl |=> $stable(clk_en_o));

  if (NUM_MOD > 8) begin : g_lane_chk
    // R3: a byte write to lane 0 keeps the upper stop bits
    a_r3_byte_lane: assert property (@(posedge clk_i) disable iff (!rst_q)
      (wr_ctrl && size_i == 2'd0 && addr_i[1:0] == 2'd0)
        |=> $stable(stop_q[NUM_MOD-1:8]));
  end

endmodule

// File: tb/test_modstop_clk_ctrl.sv
module test_modstop_clk_ctrl;

  localparam int NM = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, we;
  logic [2:0]    addr;
  logic [1:0]    size;
  logic [31:0]   wdata;
  logic          rvalid;
  logic [31:0]   rdata;
  logic [NM-1:0] clk_en;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] exp_q[$];
  logic [31:0] msk_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  modstop_clk_ctrl #(
    .NUM_MOD(NM), .DLY_BASE(2), .DLY_STEP(3), .CNT_W(8),
    .ACK_PRESENT(12'h7FF)
  ) i_modstop_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .clk_en_o(clk_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        logic [31:0] e, m;
        string t;
        e = exp_q.pop_front();
        m = msk_q.pop_front();
        t = tag_q.pop_front();
        if (m != 0) chk(t, rdata & m, e & m);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] s,
                    input logic [31:0] e, input logic [31:0] m, input string t,
                    output logic [31:0] got);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    exp_q.push_back(e); msk_q.push_back(m); tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
    got = rdata;
  endtask

  task automatic rdc(input logic [2:0] a, input logic [1:0] s,
                     input logic [31:0] e, input string t);
    logic [31:0] g;
    rd(a, s, e, 32'hFFFF_FFFF, t, g);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // software-style enable wait: poll one status bit up to 1000 times
  task automatic poll_run(input int bitn, output int polls, output bit timed_out);
    logic [31:0] g;
    timed_out = 1'b1;
    polls = 0;
    for (int k = 0; k < 1000; k++) begin
      rd(3'd4, 2'd2, 32'd0, 32'd0, "poll", g);
      polls++;
      if (g[bitn] == 1'b0) begin
        timed_out = 1'b0;
        break;
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    int  polls;
    bit  to;
    req = 0; we = 0; addr = 0; size = 0; wdata = 0;
    rst_n = 1'b0;
    idle(3);
    chk("R1 clk_en in reset", 32'(clk_en), 32'h0);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rdc(3'd0, 2'd2, 32'hFFF, "R1 ctrl reset");
    rdc(3'd4, 2'd2, 32'hFFF, "R1 status reset");
    chk("R1 clk_en after reset", 32'(clk_en), 32'h0);

    // R5 module 0, delay 2, via byte write (R3)
    wr(3'd0, 2'd0, 32'hFE);
    chk("R2 module 0 runs", 32'(clk_en), 32'h001);
    chk("R11 no rvalid after write", 32'(rvalid), 32'd0);
    idle(1);
    rdc(3'd4, 2'd2, 32'hFFF, "R5 m0 still stopped at D");
    rdc(3'd4, 2'd2, 32'hFFE, "R5 m0 running at D+1");

    // R5 module 1, delay 5, word write
    wr(3'd0, 2'd2, 32'hFFC);
    idle(4);
    rdc(3'd4, 2'd2, 32'hFFE, "R5 m1 still stopped at D");
    rdc(3'd4, 2'd2, 32'hFFC, "R5 m1 running at D+1");

    // R3 narrow writes
    wr(3'd0, 2'd1, 32'hFFFF_0F0F);
    wr(3'd1, 2'd0, 32'hAB05);
    rdc(3'd0, 2'd2, 32'h50F, "R3 half and byte merge");
    chk("R2 enables follow", 32'(clk_en), 32'hAF0);
    // R4 narrow reads
    rdc(3'd1, 2'd0, 32'h05, "R4 byte lane 1");
    rdc(3'd0, 2'd1, 32'h050F, "R4 half lane 0");
    rdc(3'd2, 2'd1, 32'h0, "R4 half lane 1");
    // R10 upper bits
    wr(3'd0, 2'd2, 32'hFFFF_FFFF);
    rdc(3'd0, 2'd2, 32'hFFF, "R10 upper bits dropped");

    // bring all modules up
    wr(3'd0, 2'd2, 32'h0);
    idle(40);
    rdc(3'd4, 2'd2, 32'h800, "R8 tied module stays 1");

    // R6 stop shows at once
    wr(3'd0, 2'd2, 32'h008);
    chk("R2 module 3 stopped", 32'(clk_en), 32'hFF7);
    rdc(3'd4, 2'd2, 32'h808, "R6 stop status immediate");

    // R7 stop during countdown restarts it (module 3, delay 11)
    wr(3'd0, 2'd2, 32'h000);
    idle(4);
    wr(3'd0, 2'd2, 32'h008);
    wr(3'd0, 2'd2, 32'h000);
    idle(10);
    rdc(3'd4, 2'd2, 32'h808, "R7 restarted count still stopped");
    rdc(3'd4, 2'd2, 32'h800, "R7 restarted count done");

    // R9 status writes ignored
    wr(3'd4, 2'd2, 32'hFFF);
    rdc(3'd0, 2'd2, 32'h000, "R9 ctrl unchanged");
    rdc(3'd4, 2'd2, 32'h800, "R9 status unchanged");

    // R8 polling on a module that never acknowledges
    poll_run(11, polls, to);
    chk("R8 timeout flagged", 32'(to), 32'd1);
    chk("R8 poll count", 32'(polls), 32'd1000);

    // polling a working module (5, delay 17) succeeds
    wr(3'd0, 2'd2, 32'h020);
    wr(3'd0, 2'd2, 32'h000);
    poll_run(5, polls, to);
    chk("R5 m5 poll succeeds", 32'(to), 32'd0);
    chk("R5 m5 poll bound", 32'(polls >= 16 && polls <= 18), 32'd1);

    idle(2);
    chk("R11 queue drained", 32'(exp_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule